// File: doc/BRIEF.md
# Task address region checker

This block guards the memory requests of one hardware task. It holds a small table of regions that host software has granted to the task. Each entry carries a region identifier, the region's size in bytes and a valid bit. Each request names a region, an offset inside it, a byte length, a read/write opcode and a tag. The block compares the request against every entry in the same cycle and checks that the transfer lies entirely inside the matched region. It then presents the request one cycle later with either a pass or a discard verdict. The surrounding data path uses the discard verdict to drop inbound and outbound data for that request. A passed request goes on to address translation.

The table is written only through a configuration port that the host drives while the task is set up. The request path cannot modify it. Requests enter and leave through valid/ready handshakes. There is one register stage between them, so a request is accepted on every cycle in which the output stage is empty or is being drained.

Top module: `region_guard`

## Requirements
- R1: After reset, out_valid is low, req_ready is high and every table entry is invalid, so any request is discarded until entries are loaded.
- R2: A configuration write (cfg_we high at a clock edge) sets the entry selected by cfg_idx to cfg_id, cfg_size and valid bit cfg_valid. cfg_valid low clears the entry. The write affects requests accepted at later edges only. A request accepted at the same edge as the write is judged against the old contents.
- R3: All entries are compared at once. A request hits when some valid entry's identifier equals req_id. When several valid entries match, the entry with the lowest index is used.
- R4: out_size carries the size of the matched entry, or zero on a miss.
- R5: out_discard is low exactly when the request hits, its length is non-zero and offset + length <= size. The sum is computed at full width, so a sum that would wrap at the offset width cannot pass.
- R6: A request with req_len equal to zero is always discarded.
- R7: A request that matches no valid entry is always discarded.
- R8: A request accepted at one clock edge appears with out_valid high after the next edge, with its tag, identifier, offset, length and opcode unchanged. out_discard belongs to that same output beat.
- R9: While out_valid is high and out_ready is low, req_ready is low and every output holds its value. With out_ready held high, one request per cycle is accepted.
- R10: The opcode (req_wr: 1 = write, 0 = read) is passed through and has no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe from host |
| cfg_idx | input | $clog2(NUM_ENTRIES) | Entry index to write |
| cfg_valid | input | 1 | Valid bit written to the entry |
| cfg_id | input | ID_W | Region identifier written to the entry |
| cfg_size | input | OFS_W+1 | Region size in bytes written to the entry |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_id | input | ID_W | Region identifier of the request |
| req_ofs | input | OFS_W | Byte offset inside the region |
| req_len | input | LEN_W | Transfer length in bytes |
| req_wr | input | 1 | Opcode, 1 = write, 0 = read |
| req_tag | input | TAG_W | Request tag |
| out_valid | output | 1 | Checked request present |
| out_ready | input | 1 | Downstream accepts the checked request |
| out_discard | output | 1 | Request must be dropped |
| out_id | output | ID_W | Region identifier, passed through |
| out_ofs | output | OFS_W | Offset, passed through |
| out_len | output | LEN_W | Length, passed through |
| out_wr | output | 1 | Opcode, passed through |
| out_tag | output | TAG_W | Tag, passed through |
| out_size | output | OFS_W+1 | Size of the matched region, zero on a miss |

## Verification
Two situations are hard to reach from the ports. The first is several valid entries that share one identifier. The bench builds it by rewriting a higher slot with an identifier that is already in use. It then shows that the lowest slot decides, and that the higher slot decides once the lower one is cleared. The second is a request that arrives at the same edge as a table write that changes its own region. The bench drives both strobes in one cycle and expects the old verdict. The bench also uses a 4-bit offset and length, which makes the full offset-by-length-by-identifier space small enough to sweep exhaustively. That sweep covers every wrap-around sum, including a region of the maximum size and a region of size zero.

// File: rtl/rgn_pkg.sv
`timescale 1ns/1ps
package rgn_pkg;

    typedef enum logic {
        RG_OP_READ  = 1'b0,
        RG_OP_WRITE = 1'b1
    } rg_op_e;

    function automatic int rg_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rgn_table.sv
`timescale 1ns/1ps
module rgn_table #(
    parameter int N      = 8,
    parameter int ID_W   = 8,
    parameter int SIZE_W = 17,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic                        wr_valid,
    input  logic [ID_W-1:0]             wr_id,
    input  logic [SIZE_W-1:0]           wr_size,
    output logic [N-1:0]                ent_valid,
    output logic [N-1:0][ID_W-1:0]      ent_id,
    output logic [N-1:0][SIZE_W-1:0]    ent_size
);

    typedef struct packed {
        logic [N-1:0]             valid;
        logic [N-1:0][ID_W-1:0]   id;
        logic [N-1:0][SIZE_W-1:0] size;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    // next-state: one slot per write strobe
    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < N; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                tbl_d.valid[i] = wr_valid;
                tbl_d.id[i]    = wr_id;
                tbl_d.size[i]  = wr_size;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign ent_valid = tbl_q.valid;
    assign ent_id    = tbl_q.id;
    assign ent_size  = tbl_q.size;

endmodule

// File: rtl/rgn_match.sv
`timescale 1ns/1ps
module rgn_match #(
    parameter int N      = 8,
    parameter int ID_W   = 8,
    parameter int SIZE_W = 17
) (
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0][ID_W-1:0]   ent_id,
    input  logic [N-1:0][SIZE_W-1:0] ent_size,
    input  logic [ID_W-1:0]          key,
    output logic                     hit,
    output logic [SIZE_W-1:0]        hit_size
);

    logic [N-1:0] hit_vec;

    // one comparator per entry, all in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g] && (ent_id[g] == key);
    end

    // lowest index wins: scan from the top so lower slots overwrite
    always_comb begin
        hit_size = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_size = ent_size[i];
            end
        end
        hit = |hit_vec;
    end

endmodule

// File: rtl/rgn_bounds.sv
`timescale 1ns/1ps
module rgn_bounds
    import rgn_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int LEN_W  = 16,
    parameter int SIZE_W = 17
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    output logic              fits
);

    // two spare bits: no sum of offset and length can wrap
    localparam int SUM_W = rg_max(rg_max(OFS_W, LEN_W) + 2, SIZE_W);

    logic [SUM_W-1:0] end_pos;

    always_comb begin
        end_pos = SUM_W'(ofs) + SUM_W'(len);
        fits    = (len != '0) && (end_pos <= SUM_W'(size));
    end

endmodule

// File: rtl/region_guard.sv
`timescale 1ns/1ps
module region_guard
    import rgn_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int ID_W        = 8,
    parameter int OFS_W       = 16,
    parameter int LEN_W       = 16,
    parameter int TAG_W       = 4,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int SIZE_W     = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_wr,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_discard,
    output logic [ID_W-1:0]   out_id,
    output logic [OFS_W-1:0]  out_ofs,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_wr,
    output logic [TAG_W-1:0]  out_tag,
    output logic [SIZE_W-1:0] out_size
);

    typedef struct packed {
        logic              vld;
        logic              discard;
        logic [ID_W-1:0]   id;
        logic [OFS_W-1:0]  ofs;
        logic [LEN_W-1:0]  len;
        rg_op_e            op;
        logic [TAG_W-1:0]  tag;
        logic [SIZE_W-1:0] size;
    } ostage_t;

    logic [NUM_ENTRIES-1:0]             ent_valid;
    logic [NUM_ENTRIES-1:0][ID_W-1:0]   ent_id;
    logic [NUM_ENTRIES-1:0][SIZE_W-1:0] ent_size;
    logic                               lk_hit;
    logic [SIZE_W-1:0]                  lk_size;
    logic                               lk_fits;
    ostage_t                            st_d, st_q;

    rgn_table #(
        .N      (NUM_ENTRIES),
        .ID_W   (ID_W),
        .SIZE_W (SIZE_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_valid  (cfg_valid),
        .wr_id     (cfg_id),
        .wr_size   (cfg_size),
        .ent_valid (ent_valid),
        .ent_id    (ent_id),
        .ent_size  (ent_size)
    );

    rgn_match #(
        .N      (NUM_ENTRIES),
        .ID_W   (ID_W),
        .SIZE_W (SIZE_W)
    ) u_match (
        .ent_valid (ent_valid),
        .ent_id    (ent_id),
        .ent_size  (ent_size),
        .key       (req_id),
        .hit       (lk_hit),
        .hit_size  (lk_size)
    );

    rgn_bounds #(
        .OFS_W  (OFS_W),
        .LEN_W  (LEN_W),
        .SIZE_W (SIZE_W)
    ) u_bounds (
        .ofs  (req_ofs),
        .len  (req_len),
        .size (lk_size),
        .fits (lk_fits)
    );

    assign req_ready = !st_q.vld || out_ready;

    // next-state of the single output stage
    always_comb begin
        st_d = st_q;
        if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
        if (req_valid && req_ready) begin
            st_d.vld     = 1'b1;
            st_d.discard = !(lk_hit && lk_fits);
            st_d.id      = req_id;
            st_d.ofs     = req_ofs;
            st_d.len     = req_len;
            st_d.op      = rg_op_e'(req_wr);
            st_d.tag     = req_tag;
            st_d.size    = lk_hit ? lk_size : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_discard = st_q.discard;
    assign out_id      = st_q.id;
    assign out_ofs     = st_q.ofs;
    assign out_len     = st_q.len;
    assign out_wr      = (st_q.op == RG_OP_WRITE);
    assign out_tag     = st_q.tag;
    assign out_size    = st_q.size;

endmodule

// File: rtl/region_guard_chk.sv
`timescale 1ns/1ps
module region_guard_chk #(
    parameter int OFS_W  = 16,
    parameter int LEN_W  = 16,
    parameter int TAG_W  = 4,
    parameter int SIZE_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [TAG_W-1:0]  req_tag,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_discard,
    input logic [OFS_W-1:0]  out_ofs,
    input logic [LEN_W-1:0]  out_len,
    input logic [TAG_W-1:0]  out_tag,
    input logic [SIZE_W-1:0] out_size
);

    localparam int CW = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + SIZE_W + 2;

    AST_PASS_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_discard) |-> ((CW'(out_ofs) + CW'(out_len)) <= CW'(out_size))); // R5

    AST_ZERO_LEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_len == '0)) |-> out_discard); // R6

    AST_NO_SIZE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_size == '0)) |-> out_discard); // R7

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_valid && (out_tag == $past(req_tag)))); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_discard)
                                       && $stable(out_size))); // R9

    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !req_ready); // R9

endmodule

bind region_guard region_guard_chk #(
    .OFS_W  (OFS_W),
    .LEN_W  (LEN_W),
    .TAG_W  (TAG_W),
    .SIZE_W (SIZE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_tag     (req_tag),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_discard (out_discard),
    .out_ofs     (out_ofs),
    .out_len     (out_len),
    .out_tag     (out_tag),
    .out_size    (out_size)
);

// File: tb/region_guard_bench.sv
`timescale 1ns/1ps
module region_guard_bench;

    localparam int NE = 8;
    localparam int IW = 4;
    localparam int OW = 4;
    localparam int LW = 4;
    localparam int TW = 4;
    localparam int XW = 3;
    localparam int SW = OW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [XW-1:0] cfg_idx = '0;
    logic          cfg_valid = 1'b0;
    logic [IW-1:0] cfg_id = '0;
    logic [SW-1:0] cfg_size = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [IW-1:0] req_id = '0;
    logic [OW-1:0] req_ofs = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_wr = 1'b0;
    logic [TW-1:0] req_tag = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic          out_discard;
    logic [IW-1:0] out_id;
    logic [OW-1:0] out_ofs;
    logic [LW-1:0] out_len;
    logic          out_wr;
    logic [TW-1:0] out_tag;
    logic [SW-1:0] out_size;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    bit m_valid [NE];
    int m_id    [NE];
    int m_size  [NE];

    always #2 clk = ~clk;

    region_guard #(
        .NUM_ENTRIES (NE), .ID_W (IW), .OFS_W (OW), .LEN_W (LW), .TAG_W (TW)
    ) u_region_guard (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_idx (cfg_idx), .cfg_valid (cfg_valid),
        .cfg_id (cfg_id), .cfg_size (cfg_size),
        .req_valid (req_valid), .req_ready (req_ready), .req_id (req_id),
        .req_ofs (req_ofs), .req_len (req_len), .req_wr (req_wr), .req_tag (req_tag),
        .out_valid (out_valid), .out_ready (out_ready), .out_discard (out_discard),
        .out_id (out_id), .out_ofs (out_ofs), .out_len (out_len), .out_wr (out_wr),
        .out_tag (out_tag), .out_size (out_size)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_size(input int id);
        for (int i = 0; i < NE; i++) begin
            if (m_valid[i] && m_id[i] == id) return m_size[i];
        end
        return 0;
    endfunction

    function automatic bit exp_hit(input int id);
        for (int i = 0; i < NE; i++) begin
            if (m_valid[i] && m_id[i] == id) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int exp_drop(input int id, input int ofs, input int len);
        if (!exp_hit(id)) return 1;
        if (len == 0) return 1;
        return (ofs + len > exp_size(id)) ? 1 : 0;
    endfunction

    task automatic cfg_write(input int idx, input bit v, input int id, input int sz);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = XW'(idx); cfg_valid = v;
        cfg_id = IW'(id); cfg_size = SW'(sz);
        @(negedge clk);
        cfg_we = 1'b0;
        m_valid[idx] = v; m_id[idx] = id; m_size[idx] = sz;
    endtask

    task automatic drive(input int id, input int ofs, input int len, input bit wr, input int tag);
        req_valid = 1'b1; req_id = IW'(id); req_ofs = OW'(ofs);
        req_len = LW'(len); req_wr = wr; req_tag = TW'(tag);
    endtask

    // one request, result checked one cycle later
    task automatic apply(input int id, input int ofs, input int len, input bit wr,
                         input int tag, input string req);
        @(negedge clk);
        drive(id, ofs, len, wr, tag);
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " discard"}, int'(out_discard), exp_drop(id, ofs, len));
        chk({req, " size"}, int'(out_size), exp_size(id));
        chk({req, " tag"}, int'(out_tag), tag & 15);
    endtask

    function automatic int slot_size(input int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 3;
            3: return 5;
            4: return 8;
            5: return 11;
            6: return 15;
            default: return 16;
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_valid[i] = 1'b0; m_id[i] = 0; m_size[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 req_ready", int'(req_ready), 1);
        apply(0, 0, 1, 1'b0, 1, "R1 empty table");

        // R2 load every slot; id = slot + 3, sizes include 0 and the maximum
        for (int i = 0; i < NE; i++) cfg_write(i, 1'b1, i + 3, slot_size(i));

        // R3 R4 R5 R6 R7 R10 exhaustive sweep (ids 0..2, 11..15 miss)
        for (int id = 0; id < 16; id++) begin
            for (int o = 0; o < 16; o++) begin
                for (int l = 0; l < 16; l++) begin
                    @(negedge clk);
                    drive(id, o, l, o[0], o + l);
                    @(negedge clk);
                    req_valid = 1'b0;
                    chk("R5 discard", int'(out_discard), exp_drop(id, o, l));
                    chk("R4 size", int'(out_size), exp_size(id));
                    chk("R8 ofs", int'(out_ofs), o);
                    chk("R8 len", int'(out_len), l);
                    chk("R8 id", int'(out_id), id);
                    chk("R10 opcode", int'(out_wr), o & 1);
                end
            end
        end
        apply(10, 0, 16 - 1, 1'b1, 3, "R5 max region");
        apply(10, 15, 15, 1'b0, 4, "R5 wrap sum");
        apply(4, 0, 1, 1'b1, 5, "R7 size-one region write");
        apply(4, 0, 0, 1'b0, 6, "R6 zero length");
        apply(2, 0, 1, 1'b0, 7, "R7 miss");

        // R3 duplicate identifier: slot 6 reuses id 5 (slot 2)
        cfg_write(6, 1'b1, 5, 15);
        apply(5, 0, 4, 1'b0, 8, "R3 lowest index");
        chk("R3 dup size", int'(out_size), 3);
        cfg_write(2, 1'b0, 5, 3);
        apply(5, 0, 4, 1'b0, 9, "R3 after clear");
        chk("R3 higher slot", int'(out_size), 15);

        // R2 write and request in the same cycle: old contents decide
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = XW'(6); cfg_valid = 1'b0; cfg_id = 4'd5; cfg_size = 5'd15;
        drive(5, 0, 4, 1'b0, 10);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        m_valid[6] = 1'b0;
        chk("R2 same-cycle discard", int'(out_discard), 0);
        chk("R2 same-cycle size", int'(out_size), 15);
        apply(5, 0, 4, 1'b0, 11, "R2 after clear");
        chk("R2 cleared drop", int'(out_discard), 1);

        // R9 backpressure
        @(negedge clk);
        out_ready = 1'b0;
        drive(3, 0, 1, 1'b0, 12);
        @(negedge clk);
        chk("R9 first out", int'(out_tag), 12);
        chk("R9 ready low", int'(req_ready), 0);
        drive(9, 0, 16 - 1, 1'b1, 13);
        @(negedge clk);
        chk("R9 held tag", int'(out_tag), 12);
        chk("R9 held valid", int'(out_valid), 1);
        chk("R9 held ready", int'(req_ready), 0);
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 second out", int'(out_tag), 13);
        chk("R9 second discard", int'(out_discard), exp_drop(9, 0, 15));
        @(negedge clk);
        chk("R9 drained", int'(out_valid), 0);

        // R8 R9 back-to-back stream
        @(negedge clk);
        drive(4, 0, 1, 1'b0, 0);
        for (int k = 1; k < 6; k++) begin
            @(negedge clk);
            chk("R9 stream ready", int'(req_ready), 1);
            chk("R8 stream tag", int'(out_tag), k - 1);
            drive(4, 0, k, 1'b0, k);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 stream last", int'(out_tag), 5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule